// File: doc/BRIEF.md
# System Control Register File with Keyed Oscillator Access

This block is a small bank of system control and status registers on a simple 32-bit register bus. Addresses are byte offsets, and the low two bits are ignored. Read data is combinational: it follows the address in the same cycle. A write takes effect on the rising clock edge while `wrEn` is high. The bank holds the following:

- two constant words, one for identification and one for status;
- two oscillator setting words, which software can change only after it writes a 16-bit unlock key to the lock register;
- a control word that drives an LED output and a boot-memory remap output, and that raises a one-cycle reset request;
- two flag words, each with separate set and clear aliases;
- a memory configuration word and a bus initialisation word;
- a free-running reference counter;
- a read-only window of memory-descriptor bytes.

A system integrator places the block at a fixed base address. The `rstReq` pulse goes to the reset controller, and `remapEn` goes to the address decoder, which unmaps the boot memory from address zero while `remapEn` is high. The reference counter advances once every `REF_DIV` clocks, which approximates the fixed reference rate.

Top module: `sysctl_regfile`

## Requirements
- R1: Byte offset 0x00 always reads 0x411A3001. Byte offset 0x10 always reads 0x00100000. Writes to either offset change nothing.
- R2: A write to the lock register at byte offset 0x14 stores only bits 15:0 of the data. A read returns the stored value with bits 31:16 equal to zero, unless R3 applies.
- R3: While the stored lock value equals 0xA05F, a read of byte offset 0x14 returns 0x0001A05F.
- R4: The oscillator words are at byte offsets 0x08 and 0x1C. They reset to 0x01000048 and 0x0007FEFF. A write to either one updates it only while the lock holds 0xA05F; at any other time the write is ignored.
- R5: The control word is at byte offset 0x0C. It stores only bits 0 and 2 of the data. A write with bit 3 set makes `rstReq` high for exactly the one cycle after the write edge. Bits other than 0 and 2 always read zero.
- R6: `led` equals control bit 0. `remapEn` equals control bit 2, so a 1 means the boot memory is unmapped from address zero. Both are 0 after reset.
- R7: The first flag word reads at 0x30. A write to 0x30 ORs the data into it, and a write to 0x34 clears the bits written as 1. The second flag word behaves the same way at 0x38 (read and set) and 0x3C (clear). Both reset to zero, and the clear offsets read zero.
- R8: Byte offset 0x28 returns a 32-bit count. The count is zero at reset and increments once every `REF_DIV` clock cycles.
- R9: The memory configuration word at 0x20 resets to 0x00011122 OR a size code, and the initialisation word at 0x24 resets to 0x00000112. Both are plain read/write words. The size code depends on `MEM_MB`:

  | `MEM_MB` | Size code |
  |---|---|
  | 256 or more | 0x10 |
  | 128 or more | 0x0C |
  | 64 or more | 0x08 |
  | 32 or more | 0x04 |
  | less than 32 | 0x00 |

- R10: Reads in byte range 0x100 to 0x17F return descriptor byte number (offset − 0x100)/4 in bits 7:0, with all other bits zero. The defined bytes are:

  | Byte | Value |
  |---|---|
  | 0 | 128 |
  | 1 | 8 |
  | 2 | 4 |
  | 31 | density code |

  The density code depends on `MEM_MB`: 64 for 256 or more, 32 for 128 or more, 16 for 64 or more, 4 for 32 or more, and 2 otherwise. Every other byte in the window reads zero, and reads from 0x180 to 0x1FF return zero.
- R11: Reads of any offset not named above return zero, and writes to such offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| rstReq | output | 1 | One-cycle system reset request |
| remapEn | output | 1 | Boot memory unmapped from address zero when high |
| led | output | 1 | LED drive, control bit 0 |

## Verification
The hardest state to reach from the ports is an oscillator write that arrives after the key has been written and then overwritten with a different value. In that state the write must fail again, even though the lock read looked correct just before. The stimulus first writes the key, updates both oscillators and confirms the new values. It then stores a near-miss key that differs from 0xA05F in one bit, attempts further writes and reads the old values back. The reference counter has no known absolute value, so it is checked by the difference between two reads taken a known number of clocks apart.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [31:0] ID_WORD     = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD   = 32'h0010_0000;
  localparam logic [15:0] LOCK_KEY    = 16'hA05F;
  localparam logic [31:0] OSC0_RST    = 32'h0100_0048;
  localparam logic [31:0] OSC1_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST    = 32'h0000_0112;
  localparam logic [31:0] MEMCFG_BASE = 32'h0001_1122;

  // word offsets
  localparam int W_ID      = 0;
  localparam int W_OSC0    = 2;
  localparam int W_CTRL    = 3;
  localparam int W_STAT    = 4;
  localparam int W_LOCK    = 5;
  localparam int W_OSC1    = 7;
  localparam int W_MEMCFG  = 8;
  localparam int W_INIT    = 9;
  localparam int W_COUNT   = 10;
  localparam int W_FLAGS   = 12;
  localparam int W_FLAGC   = 13;
  localparam int W_NVF     = 14;
  localparam int W_NVC     = 15;
  localparam int W_DESC_LO = 64;
  localparam int W_DESC_HI = 95;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_OSC0, SEL_CTRL, SEL_STAT, SEL_LOCK, SEL_OSC1,
    SEL_MEMCFG, SEL_INIT, SEL_COUNT, SEL_FLAGS, SEL_NVFLAGS, SEL_DESC
  } regSel_e;

  typedef struct packed {
    logic wrOsc0;
    logic wrOsc1;
    logic wrCtrl;
    logic wrLock;
    logic wrMemCfg;
    logic wrInit;
    logic setFlags;
    logic clrFlags;
    logic setNv;
    logic clrNv;
  } strobes_t;

  function automatic logic [7:0] sizeCode(input int mb);
    if (mb >= 256)      return 8'h10;
    else if (mb >= 128) return 8'h0C;
    else if (mb >= 64)  return 8'h08;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h00;
  endfunction

  function automatic logic [7:0] densityCode(input int mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] descByte(input logic [4:0] idx, input int mb);
    case (idx)
      5'd0:    return 8'd128;
      5'd1:    return 8'd8;
      5'd2:    return 8'd4;
      5'd31:   return densityCode(mb);
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wordIdx,
  input  logic              keyOk,
  output strobes_t          strb,
  output regSel_e           rdSel,
  output logic [4:0]        descIdx
);

  logic inDesc;

  assign inDesc  = (wordIdx >= WORD_W'(W_DESC_LO)) && (wordIdx <= WORD_W'(W_DESC_HI));
  assign descIdx = wordIdx[4:0];

  always_comb begin
    rdSel = SEL_NONE;
    if (inDesc) rdSel = SEL_DESC;
    else begin
      case (wordIdx)
        WORD_W'(W_ID):     rdSel = SEL_ID;
        WORD_W'(W_OSC0):   rdSel = SEL_OSC0;
        WORD_W'(W_CTRL):   rdSel = SEL_CTRL;
        WORD_W'(W_STAT):   rdSel = SEL_STAT;
        WORD_W'(W_LOCK):   rdSel = SEL_LOCK;
        WORD_W'(W_OSC1):   rdSel = SEL_OSC1;
        WORD_W'(W_MEMCFG): rdSel = SEL_MEMCFG;
        WORD_W'(W_INIT):   rdSel = SEL_INIT;
        WORD_W'(W_COUNT):  rdSel = SEL_COUNT;
        WORD_W'(W_FLAGS):  rdSel = SEL_FLAGS;
        WORD_W'(W_NVF):    rdSel = SEL_NVFLAGS;
        default:           rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (wordIdx)
        WORD_W'(W_OSC0):   strb.wrOsc0   = keyOk;
        WORD_W'(W_OSC1):   strb.wrOsc1   = keyOk;
        WORD_W'(W_CTRL):   strb.wrCtrl   = 1'b1;
        WORD_W'(W_LOCK):   strb.wrLock   = 1'b1;
        WORD_W'(W_MEMCFG): strb.wrMemCfg = 1'b1;
        WORD_W'(W_INIT):   strb.wrInit   = 1'b1;
        WORD_W'(W_FLAGS):  strb.setFlags = 1'b1;
        WORD_W'(W_FLAGC):  strb.clrFlags = 1'b1;
        WORD_W'(W_NVF):    strb.setNv    = 1'b1;
        WORD_W'(W_NVC):    strb.clrNv    = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter int MEM_MB  = 64,
  parameter int REF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobes_t    strb,
  input  regSel_e     rdSel,
  input  logic [4:0]  descIdx,
  input  logic [31:0] wrData,
  output logic        keyOk,
  output logic [31:0] rdData,
  output logic        rstReq,
  output logic        remapEn,
  output logic        led
);

  localparam logic [31:0] MEMCFG_RST = MEMCFG_BASE | {24'd0, sizeCode(MEM_MB)};
  localparam int          DIV_W      = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  logic [31:0] osc0, osc1, memCfg, initReg, flags, nvFlags, refCount;
  logic [15:0] lockVal;
  logic        ctrlLed, ctrlRemap, rstReqQ, refTick;

  assign keyOk = (lockVal == LOCK_KEY);

  generate
    if (REF_DIV <= 1) begin : g_nodiv
      assign refTick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] preCnt;
      assign refTick = (preCnt == DIV_W'(REF_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN)        preCnt <= '0;
        else if (refTick) preCnt <= '0;
        else              preCnt <= preCnt + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) refCount <= '0;
    else if (refTick) refCount <= refCount + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      osc0      <= OSC0_RST;
      osc1      <= OSC1_RST;
      memCfg    <= MEMCFG_RST;
      initReg   <= INIT_RST;
      lockVal   <= '0;
      ctrlLed   <= 1'b0;
      ctrlRemap <= 1'b0;
      rstReqQ   <= 1'b0;
      flags     <= '0;
      nvFlags   <= '0;
    end else begin
      if (strb.wrOsc0)   osc0    <= wrData;
      if (strb.wrOsc1)   osc1    <= wrData;
      if (strb.wrMemCfg) memCfg  <= wrData;
      if (strb.wrInit)   initReg <= wrData;
      if (strb.wrLock)   lockVal <= wrData[15:0];
      if (strb.wrCtrl) begin
        ctrlLed   <= wrData[0];
        ctrlRemap <= wrData[2];
      end
      rstReqQ <= strb.wrCtrl & wrData[3];
      if (strb.setFlags)      flags <= flags | wrData;
      else if (strb.clrFlags) flags <= flags & ~wrData;
      if (strb.setNv)         nvFlags <= nvFlags | wrData;
      else if (strb.clrNv)    nvFlags <= nvFlags & ~wrData;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_ID:      rdData = ID_WORD;
      SEL_STAT:    rdData = STAT_WORD;
      SEL_OSC0:    rdData = osc0;
      SEL_OSC1:    rdData = osc1;
      SEL_CTRL:    rdData = {29'd0, ctrlRemap, 1'b0, ctrlLed};
      SEL_LOCK:    rdData = {15'd0, keyOk, lockVal};
      SEL_MEMCFG:  rdData = memCfg;
      SEL_INIT:    rdData = initReg;
      SEL_COUNT:   rdData = refCount;
      SEL_FLAGS:   rdData = flags;
      SEL_NVFLAGS: rdData = nvFlags;
      SEL_DESC:    rdData = {24'd0, descByte(descIdx, MEM_MB)};
      default:     rdData = '0;
    endcase
  end

  assign rstReq  = rstReqQ;
  assign remapEn = ctrlRemap;
  assign led     = ctrlLed;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MEM_MB  = 64,
  parameter int REF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              rstReq,
  output logic              remapEn,
  output logic              led
);

  localparam int WORD_W = ADDR_W - 2;

  strobes_t   strb;
  regSel_e    rdSel;
  logic [4:0] descIdx;
  logic       keyOk;

  sysctl_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .wrEn    (wrEn),
    .wordIdx (addr[ADDR_W-1:2]),
    .keyOk   (keyOk),
    .strb    (strb),
    .rdSel   (rdSel),
    .descIdx (descIdx)
  );

  sysctl_dpath #(.MEM_MB(MEM_MB), .REF_DIV(REF_DIV)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .descIdx (descIdx),
    .wrData  (wrData),
    .keyOk   (keyOk),
    .rdData  (rdData),
    .rstReq  (rstReq),
    .remapEn (remapEn),
    .led     (led)
  );

endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic              rstReq,
  input logic              remapEn,
  input logic              led
);

  logic [ADDR_W-3:0] wIdx;
  logic              ctrlWr;
  assign wIdx   = addr[ADDR_W-1:2];
  assign ctrlWr = wrEn && (wIdx == (ADDR_W-2)'(3));

  p_id_const_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wIdx == '0) |-> (rdData == 32'h411A_3001));

  p_lock_upper_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wIdx == (ADDR_W-2)'(5)) |-> (rdData[31:17] == '0));

  p_lock_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wIdx == (ADDR_W-2)'(5)) |-> (rdData[16] == (rdData[15:0] == 16'hA05F)));

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[3]) |=> rstReq);

  p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(ctrlWr && wrData[3]));

  p_ctrl_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wIdx == (ADDR_W-2)'(3)) |-> ((rdData & ~32'h5) == '0));

  p_remap_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (remapEn == $past(wrData[2])) && (led == $past(wrData[0])));

  p_outs_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(remapEn) && $stable(led));

  p_desc_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wIdx >= (ADDR_W-2)'(96) && wIdx <= (ADDR_W-2)'(127)) |-> (rdData == '0));

endmodule

bind sysctl_regfile sysctl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .rstReq  (rstReq),
  .remapEn (remapEn),
  .led     (led)
);

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;

  localparam int ADDR_W  = 12;
  localparam int MEM_MB  = 64;
  localparam int REF_DIV = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              rstReq, remapEn, led;

  int checks = 0;
  int errors = 0;
  logic pendRd = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [31:0]       exp;
    string             tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  sysctl_regfile #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB), .REF_DIV(REF_DIV)) i_sysctl_regfile (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rstReq(rstReq), .remapEn(remapEn), .led(led)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read items and compares
  always @(negedge clk) begin
    if (pendRd && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk($sformatf("%s @0x%03h", it.tag, it.a), rdData, it.exp);
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    pendRd = 1'b0; addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expRd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    wrEn = 1'b0; addr = a;
    it.a = a; it.exp = exp; it.tag = tag;
    q.push_back(it);
    pendRd = 1'b1;
    @(negedge clk); #1;
    pendRd = 1'b0;
  endtask

  task automatic peek(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    wrEn = 1'b0; addr = a;
    @(negedge clk);
    v = rdData;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    expRd(12'h000, 32'h411A3001, "R1 id");
    expRd(12'h010, 32'h00100000, "R1 status");
    expRd(12'h008, 32'h01000048, "R4 osc0 reset");
    expRd(12'h01C, 32'h0007FEFF, "R4 osc1 reset");
    expRd(12'h00C, 32'h0, "R5 ctrl reset");
    expRd(12'h014, 32'h0, "R2 lock reset");
    expRd(12'h020, 32'h0001112A, "R9 memcfg reset");
    expRd(12'h024, 32'h00000112, "R9 init reset");
    expRd(12'h030, 32'h0, "R7 flags reset");
    expRd(12'h038, 32'h0, "R7 nvflags reset");
    chk("R6 remapEn reset", {31'd0, remapEn}, 32'd0);
    chk("R6 led reset", {31'd0, led}, 32'd0);

    // constants ignore writes
    wr(12'h000, 32'hFFFFFFFF);
    wr(12'h010, 32'h0);
    expRd(12'h000, 32'h411A3001, "R1 id after write");
    expRd(12'h010, 32'h00100000, "R1 status after write");

    // lock width and locked oscillators
    wr(12'h014, 32'hFFFF1234);
    expRd(12'h014, 32'h00001234, "R2 lock low half");
    wr(12'h008, 32'hDEADBEEF);
    wr(12'h01C, 32'h12345678);
    expRd(12'h008, 32'h01000048, "R4 osc0 locked");
    expRd(12'h01C, 32'h0007FEFF, "R4 osc1 locked");

    // unlock
    wr(12'h014, 32'h5555A05F);
    expRd(12'h014, 32'h0001A05F, "R3 key readback");
    wr(12'h008, 32'hCAFE0055);
    wr(12'h01C, 32'h00000077);
    expRd(12'h008, 32'hCAFE0055, "R4 osc0 unlocked");
    expRd(12'h01C, 32'h00000077, "R4 osc1 unlocked");

    // near-miss key relocks
    wr(12'h014, 32'h0000A05E);
    expRd(12'h014, 32'h0000A05E, "R3 near-miss readback");
    wr(12'h008, 32'h11111111);
    wr(12'h01C, 32'h22222222);
    expRd(12'h008, 32'hCAFE0055, "R4 osc0 relocked");
    expRd(12'h01C, 32'h00000077, "R4 osc1 relocked");

    // control and reset pulse
    chk("R5 no pulse idle", {31'd0, rstReq}, 32'd0);
    wr(12'h00C, 32'hFFFFFFFF);
    chk("R5 rstReq pulse", {31'd0, rstReq}, 32'd1);
    @(posedge clk); #1;
    chk("R5 rstReq single cycle", {31'd0, rstReq}, 32'd0);
    expRd(12'h00C, 32'h00000005, "R5 ctrl stored bits");
    chk("R6 remapEn set", {31'd0, remapEn}, 32'd1);
    chk("R6 led set", {31'd0, led}, 32'd1);
    wr(12'h00C, 32'h00000004);
    chk("R5 no pulse without bit3", {31'd0, rstReq}, 32'd0);
    chk("R6 led cleared", {31'd0, led}, 32'd0);
    chk("R6 remapEn held", {31'd0, remapEn}, 32'd1);
    wr(12'h00C, 32'h00000008);
    chk("R5 pulse bit3 only", {31'd0, rstReq}, 32'd1);
    chk("R6 remapEn cleared", {31'd0, remapEn}, 32'd0);

    // flags
    wr(12'h030, 32'h0000000F);
    wr(12'h030, 32'h000000F0);
    expRd(12'h030, 32'h000000FF, "R7 flags set OR");
    wr(12'h034, 32'h0000003C);
    expRd(12'h030, 32'h000000C3, "R7 flags clear");
    expRd(12'h034, 32'h0, "R7 clear alias reads zero");
    wr(12'h038, 32'h80000001);
    wr(12'h03C, 32'h00000001);
    expRd(12'h038, 32'h80000000, "R7 nvflags set/clear");
    expRd(12'h030, 32'h000000C3, "R7 flags independent");

    // memcfg / init
    wr(12'h020, 32'hA5A5A5A5);
    wr(12'h024, 32'h0000BEEF);
    expRd(12'h020, 32'hA5A5A5A5, "R9 memcfg rw");
    expRd(12'h024, 32'h0000BEEF, "R9 init rw");

    // counter
    peek(12'h028, v1);
    repeat (39) @(posedge clk);
    peek(12'h028, v2);
    chk("R8 counter delta over 40 clocks", v2 - v1, 32'd10);

    // descriptor window
    expRd(12'h100, 32'd128, "R10 desc byte0");
    expRd(12'h104, 32'd8, "R10 desc byte1");
    expRd(12'h108, 32'd4, "R10 desc byte2");
    expRd(12'h10C, 32'd0, "R10 desc byte3");
    expRd(12'h17C, 32'd16, "R10 desc byte31");
    expRd(12'h180, 32'd0, "R10 upper window zero");
    expRd(12'h1FC, 32'd0, "R10 upper window end zero");

    // unimplemented offsets
    wr(12'h018, 32'hFFFFFFFF);
    wr(12'h2C0, 32'hFFFFFFFF);
    expRd(12'h018, 32'h0, "R11 unimplemented read");
    expRd(12'h2C0, 32'h0, "R11 high unimplemented read");
    expRd(12'h020, 32'hA5A5A5A5, "R11 memcfg untouched");
    expRd(12'h030, 32'h000000C3, "R11 flags untouched");
    chk("R11 rstReq untouched", {31'd0, rstReq}, 32'd0);
    chk("R11 remapEn untouched", {31'd0, remapEn}, 32'd0);

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule